// File: doc/BRIEF.md
# Two-Stream Transposed FIR Summer

This block filters two independent signed sample streams, each through its own five-tap FIR section, and adds the two filtered results into one output stream. Both streams share one sample-valid strobe, so a pair of samples (one per stream) is accepted in the same cycle. Each section is built in transposed form. The incoming sample goes to all of that section's multipliers at once. The partial sums then move toward the output through a chain of registers, one add per stage. No register-to-register path is longer than one multiply followed by one add.

The two section outputs are added in a registered merge stage. A final registered stage then rounds the wide sum down to 16 bits and clamps it. The coefficients are static inputs and are changed only while reset is held. A typical setting uses Q1.15 coefficients with a rounding shift of 15, so the output has the same scale as the input.

Top module: `dual_fir_combiner`

## Requirements
- R1: For each accepted sample n, the result is the rounded and clamped value of S(n) = sum over k=0..TAPS-1 of A[k]*x1(n-k) + B[k]*x2(n-k). Here A[k] is coef_a[16k+15:16k] and B[k] is coef_b[16k+15:16k], both signed. History is counted in accepted samples only, and history from before reset is zero.
- R2: When in_valid is low, the inputs do not change any filter state, whatever values x1 and x2 carry.
- R3: If in_valid is high at a rising edge, y_valid is high during the cycle after the third rising edge, counting that edge as the first. y_valid is never high at any other time.
- R4: Rounding adds 2^(RND_SHIFT-1) to S(n) and then shifts right arithmetically by RND_SHIFT, so exact ties round toward plus infinity.
- R5: A rounded value above 32767 is output as 32767, and one below -32768 is output as -32768.
- R6: When rst is high at a clock edge, all tap registers, the merge stage and the output register are cleared to zero, and y_valid goes low.
- R7: The two streams act independently. With x1 held at zero, the output depends only on x2 and the coefficients B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample pair strobe |
| x1 | input | 16 | First stream sample, signed |
| x2 | input | 16 | Second stream sample, signed |
| coef_a | input | 16*TAPS | First-stream coefficients, tap k at bits [16k+15:16k] |
| coef_b | input | 16*TAPS | Second-stream coefficients, same layout |
| y | output | 16 | Rounded, clamped, combined result |
| y_valid | output | 1 | Result strobe |

## Verification
The bench builds the block with TAPS=5 and RND_SHIFT=15. At this scale, a unit coefficient with inputs of ±16384 and ±16385 produces exact rounding ties and values on either side of them. With full-scale samples and full-scale coefficients, a five-tap sum goes well beyond both clamp limits. Gapped streams with junk on the data pins while the strobe is low exercise the hold behaviour. Resets in the middle of a stream show that the transposed chains are cleared.

// File: rtl/dfir_pkg.sv
`timescale 1ns/1ps
package dfir_pkg;
    localparam int SAMPLE_W = 16;
    localparam int COEF_W   = 16;
    localparam int PROD_W   = SAMPLE_W + COEF_W;
    localparam int ACC_W    = 36;
    localparam int OUT_W    = 16;
    localparam int N_STREAM = 2;

    localparam logic signed [ACC_W:0] SAT_HI = (ACC_W+1)'((1 <<< (OUT_W-1)) - 1);
    localparam logic signed [ACC_W:0] SAT_LO = ~SAT_HI;
    localparam logic signed [OUT_W-1:0] OUT_MAX = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic signed [OUT_W-1:0] OUT_MIN = {1'b1, {(OUT_W-1){1'b0}}};

    typedef struct packed {
        logic                    vld;
        logic signed [ACC_W-1:0] sum;
    } acc_beat_t;

    function automatic logic signed [OUT_W-1:0] round_sat(
        input logic signed [ACC_W-1:0] v,
        input int                      sh
    );
        logic signed [ACC_W:0] w;
        w = {v[ACC_W-1], v};
        if (sh > 0) w = w + ((ACC_W+1)'(1) <<< (sh - 1));
        w = w >>> sh;
        if (w > SAT_HI)      return OUT_MAX;
        else if (w < SAT_LO) return OUT_MIN;
        else                 return w[OUT_W-1:0];
    endfunction
endpackage

// File: rtl/dfir_tap_chain.sv
`timescale 1ns/1ps
module dfir_tap_chain
    import dfir_pkg::*;
#(
    parameter int TAPS = 5
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       adv,
    input  logic signed [SAMPLE_W-1:0] x,
    input  logic [TAPS*COEF_W-1:0]     coef,
    output logic signed [ACC_W-1:0]    head
);
    logic signed [PROD_W-1:0] prod [TAPS];
    logic signed [ACC_W-1:0]  r    [TAPS];

    // broadcast: one multiplier per tap, all fed by the same sample
    generate
        for (genvar k = 0; k < TAPS; k++) begin : g_mul
            assign prod[k] = $signed(coef[k*COEF_W +: COEF_W]) * x;
        end
    endgenerate

    // transposed chain: each stage is one product plus the upstream register
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < TAPS; k++) r[k] <= '0;
        end else if (adv) begin
            for (int k = 0; k < TAPS - 1; k++) r[k] <= ACC_W'(prod[k]) + r[k+1];
            r[TAPS-1] <= ACC_W'(prod[TAPS-1]);
        end
    end

    assign head = r[0];

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(head));
endmodule

// File: rtl/dfir_out_stage.sv
`timescale 1ns/1ps
module dfir_out_stage
    import dfir_pkg::*;
#(
    parameter int RND_SHIFT = 15
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_vld,
    input  logic signed [ACC_W-1:0] sum_a,
    input  logic signed [ACC_W-1:0] sum_b,
    output logic signed [OUT_W-1:0] y,
    output logic                    y_vld
);
    acc_beat_t mrg;

    always_ff @(posedge clk) begin
        if (rst) begin
            mrg <= '0;
        end else begin
            mrg.vld <= in_vld;
            if (in_vld) mrg.sum <= sum_a + sum_b;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            y     <= '0;
            y_vld <= 1'b0;
        end else begin
            y_vld <= mrg.vld;
            if (mrg.vld) y <= round_sat(mrg.sum, RND_SHIFT);
        end
    end

    // R5
    pos_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (mrg.vld && !mrg.sum[ACC_W-1]) |=> !y[OUT_W-1]);
    // R4
    neg_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (mrg.vld && mrg.sum[ACC_W-1]) |=> (y[OUT_W-1] || y == '0));
endmodule

// File: rtl/dual_fir_combiner.sv
`timescale 1ns/1ps
module dual_fir_combiner
    import dfir_pkg::*;
#(
    parameter int TAPS      = 5,
    parameter int RND_SHIFT = 15
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] x1,
    input  logic signed [SAMPLE_W-1:0] x2,
    input  logic [TAPS*COEF_W-1:0]     coef_a,
    input  logic [TAPS*COEF_W-1:0]     coef_b,
    output logic signed [OUT_W-1:0]    y,
    output logic                       y_valid
);
    logic signed [SAMPLE_W-1:0] xs    [N_STREAM];
    logic [TAPS*COEF_W-1:0]     cs    [N_STREAM];
    logic signed [ACC_W-1:0]    heads [N_STREAM];
    logic                       chain_vld;

    assign xs[0] = x1;
    assign xs[1] = x2;
    assign cs[0] = coef_a;
    assign cs[1] = coef_b;

    generate
        for (genvar s = 0; s < N_STREAM; s++) begin : g_chain
            dfir_tap_chain #(.TAPS(TAPS)) u_chain (
                .clk  (clk),
                .rst  (rst),
                .adv  (in_valid),
                .x    (xs[s]),
                .coef (cs[s]),
                .head (heads[s])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) chain_vld <= 1'b0;
        else     chain_vld <= in_valid;
    end

    dfir_out_stage #(.RND_SHIFT(RND_SHIFT)) u_out (
        .clk    (clk),
        .rst    (rst),
        .in_vld (chain_vld),
        .sum_a  (heads[0]),
        .sum_b  (heads[1]),
        .y      (y),
        .y_vld  (y_valid)
    );

    // R3
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        y_valid |-> $past(in_valid, 3));
    // R6
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!y_valid && y == '0));
endmodule

// File: tb/sim_dual_fir_combiner.sv
`timescale 1ns/1ps
module sim_dual_fir_combiner;
    localparam int T  = 5;
    localparam int SH = 15;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [15:0] x1 = '0;
    logic signed [15:0] x2 = '0;
    logic [T*16-1:0] coef_a = '0;
    logic [T*16-1:0] coef_b = '0;
    logic signed [15:0] y;
    logic y_valid;

    dual_fir_combiner #(.TAPS(T), .RND_SHIFT(SH)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .x1(x1), .x2(x2),
        .coef_a(coef_a), .coef_b(coef_b), .y(y), .y_valid(y_valid)
    );

    always #2.5 clk = ~clk;

    typedef struct { bit v; longint yv; string tag; } exp_t;
    exp_t q[$];
    longint ca[T], cb[T], h1[T], h2[T];
    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] seed = 32'h1234_5678;

    task automatic check(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint ref_out(longint s);
        longint t;
        t = (s + (longint'(1) <<< (SH - 1))) >>> SH;
        if (t > 32767) t = 32767;
        if (t < -32768) t = -32768;
        return t;
    endfunction

    function automatic int rnd16();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'($signed(seed[31:16]));
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        for (int k = 0; k < T; k++) begin
            coef_a[k*16 +: 16] = 16'(ca[k]);
            coef_b[k*16 +: 16] = 16'(cb[k]);
            h1[k] = 0;
            h2[k] = 0;
        end
        repeat (3) @(negedge clk);
        // R6: cleared outputs while reset held
        check("R6 y_valid in reset", longint'(y_valid), 0);
        check("R6 y in reset", longint'(y), 0);
        rst = 1'b0;
        q.delete();
        for (int i = 0; i < 3; i++) q.push_back('{0, 0, "R3"});
    endtask

    task automatic step(bit v, int a, int b, string tag);
        exp_t e;
        exp_t n;
        longint s;
        @(negedge clk);
        e = q.pop_front();
        check({e.tag, " R3 y_valid"}, longint'(y_valid), longint'(e.v));
        if (e.v) check(e.tag, longint'(y), e.yv);
        in_valid = v;
        x1 = 16'(a);
        x2 = 16'(b);
        n.v = v;
        n.yv = 0;
        n.tag = tag;
        if (v) begin
            for (int k = T - 1; k > 0; k--) begin
                h1[k] = h1[k-1];
                h2[k] = h2[k-1];
            end
            h1[0] = a;
            h2[0] = b;
            s = 0;
            for (int k = 0; k < T; k++) s += ca[k] * h1[k] + cb[k] * h2[k];
            n.yv = ref_out(s);
        end
        q.push_back(n);
    endtask

    task automatic drain(string tag);
        for (int i = 0; i < T + 4; i++) step(0, rnd16(), rnd16(), tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: impulse on the first stream
        ca = '{1000, -2000, 3000, -4000, 5000};
        cb = '{700, 600, -500, 400, 300};
        do_reset();
        step(1, 32767, 0, "R1 impulse x1");
        for (int i = 0; i < T + 1; i++) step(1, 0, 0, "R1 impulse x1");
        drain("R1 drain");

        // R7: second stream alone
        step(1, 0, -32768, "R7 impulse x2");
        for (int i = 0; i < T + 1; i++) step(1, 0, 0, "R7 impulse x2");
        for (int i = 0; i < 10; i++) step(1, 0, rnd16(), "R7 x2 only");
        drain("R7 drain");

        // R2: gapped streams, junk on data pins when strobe low
        ca = '{9000, -12000, 15000, 8000, -3000};
        cb = '{-7000, 11000, 2000, -16000, 4000};
        do_reset();
        for (int i = 0; i < 80; i++) begin
            bit v;
            v = (rnd16() & 3) != 0;
            step(v, rnd16(), rnd16(), v ? "R1 stream" : "R2 gap");
        end
        drain("R2 drain");

        // R4: rounding ties and neighbours
        ca = '{1, 0, 0, 0, 0};
        cb = '{0, 0, 0, 0, 0};
        do_reset();
        step(1, 16384, 0, "R4 tie pos");
        step(1, 16383, 0, "R4 below tie");
        step(1, -16384, 0, "R4 tie neg");
        step(1, -16385, 0, "R4 past tie neg");
        step(1, 32767, 0, "R4 near one");
        drain("R4 drain");

        // R5: saturation both ways
        ca = '{32767, 32767, 32767, 32767, 32767};
        cb = '{32767, 32767, 32767, 32767, 32767};
        do_reset();
        for (int i = 0; i < 6; i++) step(1, 32767, 32767, "R5 sat high");
        for (int i = 0; i < 6; i++) step(1, -32768, -32768, "R5 sat low");
        drain("R5 drain");

        // R6: reset in the middle of a stream clears the chains
        ca = '{3000, 3000, 3000, 3000, 3000};
        cb = '{-2000, 1000, -2000, 1000, -2000};
        do_reset();
        for (int i = 0; i < 4; i++) step(1, 20000, -20000, "R6 pre-reset");
        do_reset();
        step(1, 10000, 10000, "R6 after reset");
        for (int i = 0; i < T; i++) step(1, 0, 0, "R6 after reset");
        drain("R6 drain");

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule